// File: doc/BRIEF.md
# Event Statistics Counter Bank

A bank of programmable 32-bit event counters that software reaches through a simple APB-style register port. Each counter picks one event from a 128-entry event space and one source (a CPU or bus master) from a 4-bit source field. Event strobes come in as one flat vector with 128 bits per source. Bit `s*128 + id` is event `id` from source `s`.

By default a counter counts rising edges of its selected event. A level option makes it count every cycle the event is high instead. A duration option makes it measure runs: it counts consecutive high cycles, returns to zero when the event drops, and keeps the longest run in a per-counter maximum register. Some ranges of event IDs belong to optional event groups. An event from a group that the build does not include never counts. The first control register reports the counter count and which options the build has, so software can discover them. A free-running 32-bit timestamp sits next to the counters.

Registers use byte addresses. Bits 8:7 pick the array: values at 0x000, controls at 0x080, maxima at 0x100 and the timestamp at 0x180. Bits 6:2 pick the counter.

Top module: `evtstat_bank`

## Requirements
- R1: `prdata` shows the addressed register while `psel` is high, and is zero otherwise. A write takes effect at the clock edge where `psel`, `penable` and `pwrite` are all high. Bits 8:7 of `paddr` select the array (0 value, 1 control, 2 maximum, 3 timestamp) and bits 6:2 select the counter.
- R2: The control fields read back as written: enable at bit 0, event ID at bits 10:4, source at bits 15:12, duration mode at bit 16, level mode at bit 17. Counter indices at or above the number of counters read zero and ignore writes, as do addresses with `paddr[1:0]` non-zero.
- R3: The control register of counter 0 also shows the number of counters minus one at bits 27:23. It shows the option flags at bit 18 (maximum/duration), 19 (internal-bus events), 20 (debug events), 21 (external events) and 22 (trace events). Other control registers read zero in bits 27:18.
- R4: With enable set and both modes clear, a counter adds one at each clock edge where the selected event is high and was low at the previous edge. A control write clears this edge history.
- R5: In level mode, a counter adds one at every clock edge where the selected event is high.
- R6: With enable clear, a counter holds its value. Writing zero to a control register stops the counter without clearing it.
- R7: The selected event is bit `src*128 + id` of `evt_i`. A source number at or above the number of sources never counts.
- R8: IDs 0x17–0x18 need the internal-bus option, 0x40–0x5F the debug option, 0x60–0x6F the external option and 0x70–0x7F the trace option. An ID whose option is absent never counts.
- R9: In duration mode, a counter adds one per clock edge while the event is high and becomes zero at an edge where the event is low. The maximum register takes the new count whenever that count exceeds it.
- R10: Value, maximum and timestamp registers are writable. A value write wins over a same-cycle increment.
- R11: The timestamp adds one every clock cycle unless written, and wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | 9 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| evt_i | input | NUM_SRC*128 | Event strobes, 128 per source |

## Verification
The same event is driven in three shapes: a run of high cycles, a gap, then one more high cycle. In edge mode the result counts the runs, in level mode it counts the high cycles, and in duration mode it gives the longest run with a reset to zero in the gaps. The gating check uses IDs at the edges of each group, with option flags both present and absent. The source check drives the same ID on every source while an out-of-range source is selected. Writes are also made while an event is held, which shows whether the write beats the increment.

// File: rtl/evtstat_pkg.sv
package evtstat_pkg;

    localparam int EVT_IDS = 128;
    localparam int ID_W    = 7;
    localparam int SRC_W   = 4;
    localparam int WORD_W  = 32;

    typedef struct packed {
        logic             lvl;
        logic             dur;
        logic [SRC_W-1:0] src;
        logic [ID_W-1:0]  id;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SP_VAL  = 2'd0,
        SP_CTRL = 2'd1,
        SP_MAX  = 2'd2,
        SP_TS   = 2'd3
    } space_e;

    function automatic ctrl_t ctrl_from_word(logic [WORD_W-1:0] w, bit allow_max);
        ctrl_t c;
        c.en  = w[0];
        c.id  = w[10:4];
        c.src = w[15:12];
        c.dur = w[16] & allow_max;
        c.lvl = w[17] & allow_max;
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(ctrl_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[0]     = c.en;
        w[10:4]  = c.id;
        w[15:12] = c.src;
        w[16]    = c.dur;
        w[17]    = c.lvl;
        return w;
    endfunction

    function automatic logic id_permitted(logic [ID_W-1:0] id, bit ibus, bit dbg,
                                          bit ext, bit trc);
        logic ok;
        ok = 1'b1;
        if (id == 7'h17 || id == 7'h18) ok = ibus;
        else if (id[6:5] == 2'b10)      ok = dbg;
        else if (id[6:4] == 3'b110)     ok = ext;
        else if (id[6:4] == 3'b111)     ok = trc;
        return ok;
    endfunction

endpackage

// File: rtl/evtstat_sel.sv
module evtstat_sel
    import evtstat_pkg::*;
#(
    parameter int NUM_SRC  = 4,
    parameter bit HAS_IBUS = 1'b1,
    parameter bit HAS_DBG  = 1'b0,
    parameter bit HAS_EXT  = 1'b1,
    parameter bit HAS_TRC  = 1'b0
) (
    input  logic [NUM_SRC*EVT_IDS-1:0] evt_i,
    input  ctrl_t                      cfg,
    output logic                       hit
);
    logic [EVT_IDS-1:0] per_src [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign per_src[s] = evt_i[s*EVT_IDS +: EVT_IDS];
    end

    logic raw;
    always_comb begin
        raw = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (cfg.src == SRC_W'(s)) raw = per_src[s][cfg.id];
        end
        hit = raw & id_permitted(cfg.id, HAS_IBUS, HAS_DBG, HAS_EXT, HAS_TRC);
    end
endmodule

// File: rtl/evtstat_slot.sv
module evtstat_slot
    import evtstat_pkg::*;
#(
    parameter bit HAS_MAX = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_val,
    input  logic              wr_ctrl,
    input  logic              wr_max,
    input  logic [WORD_W-1:0] wdata,
    input  logic              hit,
    output ctrl_t             cfg,
    output logic [WORD_W-1:0] val,
    output logic [WORD_W-1:0] maxv
);
    ctrl_t             cfg_q;
    logic [WORD_W-1:0] val_q, max_q;
    logic              prev_q;
    logic [WORD_W-1:0] run_next;

    assign run_next = val_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            val_q  <= '0;
            max_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= wr_ctrl ? 1'b0 : hit;
            if (wr_ctrl) cfg_q <= ctrl_from_word(wdata, HAS_MAX);

            if (wr_val) begin
                val_q <= wdata;
            end else if (cfg_q.en) begin
                if (cfg_q.dur)
                    val_q <= hit ? run_next : '0;
                else if (cfg_q.lvl ? hit : (hit & ~prev_q))
                    val_q <= run_next;
            end

            if (wr_max)
                max_q <= wdata;
            else if (cfg_q.en && cfg_q.dur && hit && !wr_val && run_next > max_q)
                max_q <= run_next;
        end
    end

    assign cfg  = cfg_q;
    assign val  = val_q;
    assign maxv = max_q;

    p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && !wr_val) |=> (val_q == $past(val_q)));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_val |=> (val_q == $past(wdata)));

    p_dur_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && cfg_q.dur && !hit && !wr_val) |=> (val_q == '0));
endmodule

// File: rtl/evtstat_bank.sv
module evtstat_bank
    import evtstat_pkg::*;
#(
    parameter int NUM_CNT  = 4,
    parameter int NUM_SRC  = 4,
    parameter bit HAS_MAX  = 1'b1,
    parameter bit HAS_IBUS = 1'b1,
    parameter bit HAS_DBG  = 1'b0,
    parameter bit HAS_EXT  = 1'b1,
    parameter bit HAS_TRC  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       psel,
    input  logic                       penable,
    input  logic                       pwrite,
    input  logic [8:0]                 paddr,
    input  logic [31:0]                pwdata,
    output logic [31:0]                prdata,
    input  logic [NUM_SRC*EVT_IDS-1:0] evt_i
);
    localparam logic [31:0] CAP_WORD = {4'b0, 5'(NUM_CNT - 1), HAS_TRC, HAS_EXT,
                                        HAS_DBG, HAS_IBUS, HAS_MAX, 18'b0};

    space_e     space;
    logic [4:0] idx;
    logic       aligned, do_wr;

    assign space   = space_e'(paddr[8:7]);
    assign idx     = paddr[6:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign do_wr   = psel && penable && pwrite && aligned;

    ctrl_t             cfgs [NUM_CNT];
    logic [WORD_W-1:0] vals [NUM_CNT];
    logic [WORD_W-1:0] maxs [NUM_CNT];

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic hit, sel_me;
        assign sel_me = do_wr && (idx == 5'(i));

        evtstat_sel #(
            .NUM_SRC (NUM_SRC), .HAS_IBUS(HAS_IBUS), .HAS_DBG(HAS_DBG),
            .HAS_EXT (HAS_EXT), .HAS_TRC (HAS_TRC)
        ) u_sel (
            .evt_i (evt_i),
            .cfg   (cfgs[i]),
            .hit   (hit)
        );

        evtstat_slot #(.HAS_MAX(HAS_MAX)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_val  (sel_me && space == SP_VAL),
            .wr_ctrl (sel_me && space == SP_CTRL),
            .wr_max  (sel_me && space == SP_MAX),
            .wdata   (pwdata),
            .hit     (hit),
            .cfg     (cfgs[i]),
            .val     (vals[i]),
            .maxv    (maxs[i])
        );
    end

    logic [WORD_W-1:0] ts_q;
    logic              ts_wr;
    assign ts_wr = do_wr && space == SP_TS && idx == 5'd0;

    always_ff @(posedge clk) begin
        if (rst)        ts_q <= '0;
        else if (ts_wr) ts_q <= pwdata;
        else            ts_q <= ts_q + 1'b1;
    end

    always_comb begin
        prdata = '0;
        if (psel && aligned) begin
            if (space == SP_TS) begin
                if (idx == 5'd0) prdata = ts_q;
            end else begin
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (idx == 5'(i)) begin
                        case (space)
                            SP_VAL:  prdata = vals[i];
                            SP_CTRL: prdata = ctrl_to_word(cfgs[i]) | ((i == 0) ? CAP_WORD : '0);
                            SP_MAX:  prdata = maxs[i];
                            default: prdata = '0;
                        endcase
                    end
                end
            end
        end
    end

    p_ts_step_r11: assert property (@(posedge clk) disable iff (rst)
        !ts_wr |=> (ts_q == $past(ts_q) + 32'd1));

    p_caps_r3: assert property (@(posedge clk) disable iff (rst)
        (psel && paddr == 9'h080) |-> (prdata[27:18] == CAP_WORD[27:18]));
endmodule

// File: tb/evtstat_bank_tb.sv
module evtstat_bank_tb;
    localparam int NSRC = 4;
    localparam logic [31:0] CAPS = (32'd3 << 23) | (32'd1 << 18) | (32'd1 << 19) | (32'd1 << 21);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic psel = 0, penable = 0, pwrite = 0;
    logic [8:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [NSRC*128-1:0] evt = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evtstat_bank u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .evt_i(evt)
    );

    function automatic logic [31:0] mk(bit en, int id, int src, bit dur, bit lvl);
        return {14'b0, lvl, dur, 4'(src), 1'b0, 7'(id), 3'b0, en};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        #1 d = prdata;
        psel = 0;
    endtask

    task automatic ev(int src, int id, bit v);
        evt[src*128 + id] = v;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(9'h000, d); chk("R1 value0 after reset", d, 0);
        rd(9'h080, d); chk("R3 ctrl0 caps", d, CAPS);
        rd(9'h084, d); chk("R3 ctrl1 no caps", d, 0);
        psel = 0; paddr = 9'h080; #1 chk("R1 prdata zero without psel", prdata, 0);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(9'h080, mk(1, 'h05, 1, 0, 0));
        wr(9'h000, 0);
        ev(1, 'h05, 1); cyc(3); ev(1, 'h05, 0); cyc(2);
        ev(1, 'h05, 1); cyc(1); ev(1, 'h05, 0); cyc(1);
        rd(9'h000, d); chk("R4 edge count", d, 2);
        rd(9'h080, d); chk("R2 ctrl0 readback", d, mk(1, 'h05, 1, 0, 0) | CAPS);
    endtask

    task automatic t_level_hold;
        logic [31:0] d;
        wr(9'h084, mk(1, 'h20, 0, 0, 1));
        wr(9'h004, 0);
        ev(0, 'h20, 1); cyc(5); ev(0, 'h20, 0); cyc(1);
        rd(9'h004, d); chk("R5 level count", d, 5);
        wr(9'h084, 0);
        ev(0, 'h20, 1); cyc(3); ev(0, 'h20, 0); cyc(1);
        rd(9'h004, d); chk("R6 disabled holds", d, 5);
        rd(9'h084, d); chk("R6 ctrl zero", d, 0);
    endtask

    task automatic t_source;
        logic [31:0] d;
        wr(9'h088, mk(1, 'h10, 7, 0, 1));
        wr(9'h008, 0);
        for (int s = 0; s < NSRC; s++) ev(s, 'h10, 1);
        cyc(4);
        for (int s = 0; s < NSRC; s++) ev(s, 'h10, 0);
        cyc(1);
        rd(9'h008, d); chk("R7 out-of-range source", d, 0);
        wr(9'h088, mk(1, 'h10, 3, 0, 1));
        ev(3, 'h10, 1); ev(2, 'h11, 1); cyc(4); ev(3, 'h10, 0); ev(2, 'h11, 0); cyc(1);
        rd(9'h008, d); chk("R7 source 3", d, 4);
        rd(9'h088, d); chk("R2 ctrl2 readback", d, mk(1, 'h10, 3, 0, 1));
    endtask

    task automatic t_gate;
        logic [31:0] d;
        int ids [6] = '{'h45, 'h62, 'h75, 'h17, 'h5F, 'h6F};
        int exp [6] = '{0, 3, 0, 3, 0, 3};
        for (int k = 0; k < 6; k++) begin
            wr(9'h08C, mk(1, ids[k], 0, 0, 1));
            wr(9'h00C, 0);
            ev(0, ids[k], 1); cyc(3); ev(0, ids[k], 0); cyc(1);
            rd(9'h00C, d); chk($sformatf("R8 group gating id %h", ids[k]), d, exp[k]);
        end
    endtask

    task automatic t_duration;
        logic [31:0] d;
        wr(9'h080, mk(1, 'h05, 1, 1, 0));
        wr(9'h000, 0);
        wr(9'h100, 0);
        ev(1, 'h05, 1); cyc(3);
        rd(9'h000, d); chk("R9 run count", d, 3);
        rd(9'h100, d); chk("R9 max follows", d, 3);
        ev(1, 'h05, 0); cyc(1);
        rd(9'h000, d); chk("R9 drop clears", d, 0);
        ev(1, 'h05, 1); cyc(2); ev(1, 'h05, 0); cyc(1);
        rd(9'h100, d); chk("R9 short run keeps max", d, 3);
        ev(1, 'h05, 1); cyc(5); ev(1, 'h05, 0); cyc(1);
        rd(9'h100, d); chk("R9 longer run raises max", d, 5);
    endtask

    task automatic t_writes;
        logic [31:0] d;
        wr(9'h084, mk(1, 'h20, 0, 0, 1));
        ev(0, 'h20, 1); cyc(2);
        wr(9'h004, 100); ev(0, 'h20, 0);
        rd(9'h004, d); chk("R10 write beats increment", d, 100);
        ev(0, 'h20, 1); cyc(1); ev(0, 'h20, 0);
        rd(9'h004, d); chk("R10 counts on from preset", d, 101);
        wr(9'h104, 32'h1234);
        rd(9'h104, d); chk("R10 max writable", d, 32'h1234);
        wr(9'h094, mk(1, 'h20, 0, 0, 1));
        rd(9'h094, d); chk("R2 missing counter ctrl", d, 0);
        rd(9'h014, d); chk("R2 missing counter value", d, 0);
        wr(9'h006, 32'h55);
        rd(9'h004, d); chk("R2 misaligned write ignored", d, 101);
    endtask

    task automatic t_timestamp;
        logic [31:0] d, a;
        rd(9'h180, a); cyc(7);
        rd(9'h180, d); chk("R11 timestamp step", d, a + 7);
        wr(9'h180, 32'hFFFF_FFFE);
        rd(9'h180, d); chk("R10 timestamp written", d, 32'hFFFF_FFFE);
        cyc(1); rd(9'h180, d); chk("R11 timestamp top", d, 32'hFFFF_FFFF);
        cyc(1); rd(9'h180, d); chk("R11 timestamp wrap", d, 0);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        t_reset;
        t_edge;
        t_level_hold;
        t_source;
        t_gate;
        t_duration;
        t_writes;
        t_timestamp;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule